// File: doc/BRIEF.md
# HDMI Audio Sample Packet Assembler

This block turns a stream of 24-bit audio samples into HDMI audio sample packets. Each packet is a 3-byte header and four 7-byte subpackets. A set of static control inputs chooses the packing arrangement, the channel count and the marking bits. Layout 0 carries one stereo frame in subpacket 0. Layout 1 carries one multichannel frame across as many subpackets as the channel count needs. Every input sample is tagged with its channel index, and the channel-0 sample can also carry a flag that marks the first frame of a 192-frame IEC 60958 block. The block emits one packet at a time on a valid/ready output.

If the sample source runs dry between frames, the block fills the gap. It sends either an all-zero "silent" audio packet with the flat bits set, or a null packet, depending on a control bit. The enable control only takes effect at video frame boundaries. A rising enable waits for the next vertical-blank strobe. A dropped enable lets output run on until the end-of-active-frame strobe.

Top module: `hdmi_aud_pktz`

## Requirements
- R1: In layout 1, the 3-bit channel code c selects c+2 channels (code 7 is treated as 8). Header bits 11:8 (HB1 bits 3:0) are the sample-present mask: bit k is set when 2k is less than the effective channel count.
- R2: With cfg_keep_odd low, an odd channel count in layout 1 is rounded up to the next even count, so the frame completes on channel index count. With cfg_keep_odd high, the frame completes on index count-1 and the missing right sample is zero.
- R3: Layout 0 always uses 2 channels, so the packet has present mask 0001 and header bit 12 (the layout flag) clear. Layout 1 sets header bit 12.
- R4: When src_avail is low, no sample of a frame is pending and s_valid is low, the running block with cfg_silent high sends an audio packet (HB0 = 02h) with zero samples and flat bits (header 19:16) equal to the present mask.
- R5: In the same underrun condition with cfg_silent low, the block sends a null packet, with header and body all zero.
- R6: Every present subpacket carries, in its byte 6, V in bits 0/4 (equal to cfg_v_keep), U in bits 1/5 (equal to cfg_u_force), C in bits 2/6 (always 0) and P in bits 3/7. P makes each 24-bit sample plus its V, U and C bits even parity. Sample L is subpacket bits 23:0 and sample R is bits 47:24. Absent subpackets are zero.
- R7: With cfg_flat high, the flat bits of a sample packet equal the present mask. With cfg_flat low they are zero.
- R8: A frame index counts completed frames modulo 192. It starts at 0 after reset and is forced to 0 by s_frame_start on the frame's channel-0 sample. On index 0, B (header 23:20) is set on subpacket 0 only, except in layout 1 with cfg_b_all high, where B is set on every present subpacket.
- R9: A raised cfg_enable accepts no samples and sends no packets until a vblank_start pulse arrives.
- R10: After cfg_enable drops, samples are still accepted and packed until an active_end pulse. After that pulse, nothing further is accepted or sent.
- R11: A cfg_format value other than 00 blocks sample acceptance and all packet output, including underrun packets.
- R12: A presented packet stays valid and unchanged until p_ready is high. While a packet is presented, s_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Audio output enable |
| cfg_layout | input | 1 | 0: stereo layout, 1: multichannel layout |
| cfg_lanes | input | 3 | Channel count code (count minus two) |
| cfg_format | input | 2 | Stream format; only 00 is accepted |
| cfg_keep_odd | input | 1 | Keep an odd channel count as it is |
| cfg_flat | input | 1 | Mark present subpackets as flat |
| cfg_u_force | input | 1 | Value of the U bit in each subframe |
| cfg_v_keep | input | 1 | Value of the V bit in each subframe |
| cfg_b_all | input | 1 | Layout 1: B on all present subpackets |
| cfg_silent | input | 1 | Underrun fill: 1 silent packet, 0 null packet |
| vblank_start | input | 1 | Vertical-blank start strobe |
| active_end | input | 1 | End-of-active-frame strobe |
| src_avail | input | 1 | Sample source has data |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_data | input | 24 | Audio sample |
| s_chan | input | 3 | Channel index of the sample |
| s_frame_start | input | 1 | Block-start tag on the channel-0 sample |
| p_valid | output | 1 | Packet valid |
| p_ready | input | 1 | Packet taken when high with p_valid |
| p_header | output | 24 | HB0 in 7:0, HB1 in 15:8, HB2 in 23:16 |
| p_body | output | 224 | Subpacket k in bits 56k+55:56k |

## Verification
Underrun fill and sample arrival compete for the same free output slot. The bench provokes this by dropping src_avail and sending a frame inside that window, so that s_valid rises in a cycle where a fill packet would otherwise be loaded. Each packet is then judged either as a match to the fill template or as the exact frame expected from the scoreboard. A second collision is also provoked: a frame completes while the enable is already low, just before the active_end pulse. That packet must still arrive, and nothing may follow the pulse.

// File: rtl/aspk_pkg.sv
package aspk_pkg;
  localparam int SMP_W = 24;
  localparam int SP_N  = 4;
  localparam int CH_N  = 2 * SP_N;
  localparam int SP_W  = 2 * SMP_W + 8;
  localparam int HDR_W = 24;
  localparam logic [7:0] HB0_AUDIO = 8'h02;
  localparam logic [7:0] HB0_NULL  = 8'h00;

  // effective channel count for the current control word
  function automatic logic [3:0] lane_count(logic [2:0] code, logic layout, logic keep_odd);
    logic [3:0] n;
    if (!layout) return 4'd2;
    n = (code == 3'b111) ? 4'd8 : {1'b0, code} + 4'd2;
    if (!keep_odd && n[0]) n = n + 4'd1;
    return n;
  endfunction

  // subpacket k is in use when it holds at least one channel
  function automatic logic [SP_N-1:0] present_mask(logic [3:0] n);
    logic [SP_N-1:0] m;
    for (int k = 0; k < SP_N; k++) m[k] = (4'(2 * k) < n);
    return m;
  endfunction

  // parity bit that makes sample, V, U and C together even
  function automatic logic even_par(logic [SMP_W-1:0] s, logic v, logic u);
    return ^{s, 1'b0, u, v};
  endfunction
endpackage

// File: rtl/aspk_run_gate.sv
module aspk_run_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vb_start,
  input  logic act_end,
  output logic running
);
  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b0;
    else if (!running && en && vb_start) running <= 1'b1;
    else if (running && !en && act_end) running <= 1'b0;
  end

  AST_START_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(vb_start) && $past(en)); // R9
  AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(act_end) && !$past(en)); // R10
endmodule

// File: rtl/aspk_block_ctr.sv
module aspk_block_ctr #(
  parameter int BLOCK_LEN = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_take,
  input  logic first_tag,
  input  logic frame_done,
  output logic blk_start
);
  localparam int IW = $clog2(BLOCK_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(BLOCK_LEN - 1);

  logic [IW-1:0] next_pos, cur_idx;
  logic tag_q;

  assign cur_idx   = tag_q ? '0 : next_pos;
  assign blk_start = (cur_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q    <= 1'b0;
      next_pos <= '0;
    end else begin
      if (first_take) tag_q <= first_tag;
      else if (frame_done) tag_q <= 1'b0;
      if (frame_done) next_pos <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(next_pos) < BLOCK_LEN); // R8
  AST_TAG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && tag_q |=> next_pos == IW'(1)); // R8
endmodule

// File: rtl/aspk_pkt_build.sv
module aspk_pkt_build
  import aspk_pkg::*;
(
  input  logic                    is_null,
  input  logic                    is_silent,
  input  logic [CH_N*SMP_W-1:0]   smp,
  input  logic [3:0]              lanes,
  input  logic                    layout,
  input  logic                    flat_cfg,
  input  logic                    u_force,
  input  logic                    v_keep,
  input  logic                    blk_start,
  input  logic                    b_all,
  output logic [HDR_W-1:0]        hdr,
  output logic [SP_N*SP_W-1:0]    body
);
  logic [SP_N-1:0] pres, flat_m, b_m;

  assign pres   = present_mask(lanes);
  assign flat_m = (is_silent || flat_cfg) ? pres : '0;

  always_comb begin
    b_m = '0;
    if (blk_start) begin
      if (layout && b_all) b_m = pres;
      else b_m[0] = 1'b1;
    end
  end

  for (genvar k = 0; k < SP_N; k++) begin : g_sub
    logic [SMP_W-1:0] l_s, r_s;
    logic             l_p, r_p;
    assign l_s = (pres[k] && !is_silent) ? smp[(2*k)*SMP_W +: SMP_W]   : '0;
    assign r_s = (pres[k] && !is_silent) ? smp[(2*k+1)*SMP_W +: SMP_W] : '0;
    assign l_p = even_par(l_s, v_keep, u_force);
    assign r_p = even_par(r_s, v_keep, u_force);
    assign body[k*SP_W +: SP_W] = (pres[k] && !is_null)
      ? {r_p, 1'b0, u_force, v_keep, l_p, 1'b0, u_force, v_keep, r_s, l_s}
      : '0;
  end

  assign hdr = is_null ? '0 : {b_m, flat_m, 3'b000, layout, pres, HB0_AUDIO};
endmodule

// File: rtl/hdmi_aud_pktz.sv
module hdmi_aud_pktz
  import aspk_pkg::*;
#(
  parameter int BLOCK_LEN = 192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_layout,
  input  logic [2:0]           cfg_lanes,
  input  logic [1:0]           cfg_format,
  input  logic                 cfg_keep_odd,
  input  logic                 cfg_flat,
  input  logic                 cfg_u_force,
  input  logic                 cfg_v_keep,
  input  logic                 cfg_b_all,
  input  logic                 cfg_silent,
  input  logic                 vblank_start,
  input  logic                 active_end,
  input  logic                 src_avail,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SMP_W-1:0]     s_data,
  input  logic [2:0]           s_chan,
  input  logic                 s_frame_start,
  output logic                 p_valid,
  input  logic                 p_ready,
  output logic [HDR_W-1:0]     p_header,
  output logic [SP_N*SP_W-1:0] p_body
);
  logic                    running, fmt_ok, take, in_range, frame_done, pending;
  logic                    filler_go, pkt_load, blk_start;
  logic [3:0]              lanes;
  logic [CH_N*SMP_W-1:0]   buf_q, buf_now;
  logic [HDR_W-1:0]        hdr_w;
  logic [SP_N*SP_W-1:0]    body_w;

  aspk_run_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable),
    .vb_start(vblank_start), .act_end(active_end), .running(running)
  );

  assign fmt_ok     = (cfg_format == 2'b00);
  assign lanes      = lane_count(cfg_lanes, cfg_layout, cfg_keep_odd);
  assign s_ready    = running && fmt_ok && !p_valid;
  assign take       = s_valid && s_ready;
  assign in_range   = ({1'b0, s_chan} < lanes);
  assign frame_done = take && ({1'b0, s_chan} == lanes - 4'd1);
  assign filler_go  = running && fmt_ok && !p_valid && !src_avail && !pending && !s_valid;
  assign pkt_load   = frame_done || filler_go;

  // current sample merged into the frame buffer, seen by the builder at once
  always_comb begin
    buf_now = buf_q;
    if (take && in_range) buf_now[int'(s_chan)*SMP_W +: SMP_W] = s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      pending <= 1'b0;
    end else if (frame_done || !running) begin
      buf_q   <= '0;
      pending <= 1'b0;
    end else begin
      buf_q <= buf_now;
      if (take) pending <= 1'b1;
    end
  end

  aspk_block_ctr #(.BLOCK_LEN(BLOCK_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .first_take(take && s_chan == 3'd0), .first_tag(s_frame_start),
    .frame_done(frame_done), .blk_start(blk_start)
  );

  aspk_pkt_build u_build (
    .is_null(filler_go && !cfg_silent), .is_silent(filler_go && cfg_silent),
    .smp(buf_now), .lanes(lanes), .layout(cfg_layout), .flat_cfg(cfg_flat),
    .u_force(cfg_u_force), .v_keep(cfg_v_keep),
    .blk_start(blk_start && !filler_go), .b_all(cfg_b_all),
    .hdr(hdr_w), .body(body_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid  <= 1'b0;
      p_header <= '0;
      p_body   <= '0;
    end else if (pkt_load) begin
      p_valid  <= 1'b1;
      p_header <= hdr_w;
      p_body   <= body_w;
    end else if (p_ready) begin
      p_valid  <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && !p_ready |=> p_valid && $stable(p_header) && $stable(p_body)); // R12
  AST_FMT_ONLY_PCM: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_load |-> cfg_format == 2'b00); // R11
  AST_NULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && p_header[7:0] == HB0_NULL |-> p_header == '0 && p_body == '0); // R5
  AST_FLAT_IN_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (p_header[19:16] & ~p_header[11:8]) == 4'b0000); // R7
  AST_B_IN_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (p_header[23:20] & ~p_header[11:8]) == 4'b0000); // R8
  AST_NO_LOAD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !$rose(p_valid)); // R10
endmodule

// File: tb/hdmi_aud_pktz_test.sv
`timescale 1ns/1ps
module hdmi_aud_pktz_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 0, cfg_layout = 0, cfg_keep_odd = 0, cfg_flat = 0;
  logic cfg_u_force = 0, cfg_v_keep = 1, cfg_b_all = 1, cfg_silent = 1;
  logic [2:0] cfg_lanes = 0;
  logic [1:0] cfg_format = 0;
  logic vblank_start = 0, active_end = 0, src_avail = 1;
  logic s_valid = 0, s_ready, s_frame_start = 0;
  logic [23:0] s_data = 0;
  logic [2:0] s_chan = 0;
  logic p_valid, p_ready = 1;
  logic [23:0] p_header;
  logic [223:0] p_body;

  hdmi_aud_pktz uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, bidx = 0, seed = 1, fill_seen = 0;
  bit fill_ok = 0, done = 0;
  logic [23:0] fill_hdr;
  logic [223:0] fill_body;
  logic [23:0] exp_hdr[$];
  logic [223:0] exp_body[$];
  string exp_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int x_lanes();
    int n;
    if (!cfg_layout) return 2;
    n = (cfg_lanes == 3'd7) ? 8 : int'(cfg_lanes) + 2;
    if (!cfg_keep_odd && (n % 2 == 1)) n = n + 1;
    return n;
  endfunction

  function automatic logic [23:0] x_hdr(int n, bit flat, bit bset);
    logic [3:0] pres = 0, bb = 0;
    for (int k = 0; k < (n + 1) / 2; k++) pres[k] = 1'b1;
    if (bset) bb = (cfg_layout && cfg_b_all) ? pres : 4'b0001;
    return {bb, flat ? pres : 4'b0000, 3'b000, cfg_layout, pres, 8'h02};
  endfunction

  function automatic logic [223:0] x_body(logic [191:0] s, int n);
    logic [223:0] b = '0;
    for (int k = 0; k < (n + 1) / 2; k++) begin
      logic [23:0] l, r;
      logic pl, pr;
      l = s[48*k +: 24];
      r = (2 * k + 1 < n) ? s[48*k + 24 +: 24] : 24'h0;
      pl = (^l) ^ cfg_u_force ^ cfg_v_keep;
      pr = (^r) ^ cfg_u_force ^ cfg_v_keep;
      b[56*k +: 56] = {pr, 1'b0, cfg_u_force, cfg_v_keep, pl, 1'b0, cfg_u_force, cfg_v_keep, r, l};
    end
    return b;
  endfunction

  task automatic put(input logic [23:0] d, input int c, input bit fs);
    s_valid = 1; s_data = d; s_chan = 3'(c); s_frame_start = fs;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #1;
    s_valid = 0; s_frame_start = 0;
  endtask

  task automatic send_frame(input bit fs, input string tag);
    logic [191:0] s = '0;
    int n, idx;
    n = x_lanes();
    for (int c = 0; c < n; c++) s[24*c +: 24] = 24'(seed * 131 + c * 7919 + 24'h100001);
    seed++;
    idx = fs ? 0 : bidx;
    bidx = (idx == 191) ? 0 : idx + 1;
    exp_hdr.push_back(x_hdr(n, cfg_flat, idx == 0));
    exp_body.push_back(x_body(s, n));
    exp_tag.push_back(tag);
    for (int c = 0; c < n; c++) put(s[24*c +: 24], c, fs && c == 0);
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_hdr.size() != 0 || p_valid);
    #1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && p_valid && p_ready) begin
      if (fill_ok && p_header == fill_hdr && p_body == fill_body) fill_seen++;
      else if (exp_hdr.size() != 0) begin
        chk(p_header == exp_hdr[0] && p_body == exp_body[0], exp_tag[0],
            {p_header, p_body}, {exp_hdr[0], exp_body[0]});
        void'(exp_hdr.pop_front()); void'(exp_body.pop_front()); void'(exp_tag.pop_front());
      end else chk(1'b0, "R11 unexpected packet", {p_header, p_body}, '0);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      chk(1'b0, "watchdog", 256'(cyc), 0);
      summary();
    end
  end

  initial begin
    logic [23:0] held;
    tick(3);
    rst_n = 1;
    tick(1);
    chk(p_valid == 0, "R12 reset p_valid", 256'(p_valid), 0);
    chk(s_ready == 0, "R9 reset s_ready", 256'(s_ready), 0);

    // R9: enable waits for vblank
    cfg_enable = 1;
    tick(5);
    chk(s_ready == 0, "R9 before vblank", 256'(s_ready), 0);
    vblank_start = 1; tick(1); vblank_start = 0;
    chk(s_ready == 1, "R9 after vblank", 256'(s_ready), 1);

    // R3 layout 0, R8 tagged start, R6 U/V, R7 flat
    send_frame(1, "R3 layout0 tagged");
    send_frame(0, "R3 layout0 plain");
    drain();
    cfg_u_force = 1; cfg_v_keep = 0;
    send_frame(0, "R6 U forced V cleared");
    drain();
    cfg_u_force = 0; cfg_v_keep = 1; cfg_flat = 1;
    send_frame(0, "R7 flat layout0");
    drain();

    // R1/R2 layout 1
    cfg_layout = 1; cfg_lanes = 3'b000;
    send_frame(0, "R1 layout1 two ch");
    drain();
    cfg_lanes = 3'b011;
    send_frame(0, "R2 five rounded to six");
    drain();
    cfg_keep_odd = 1;
    send_frame(0, "R2 five kept odd");
    drain();
    cfg_keep_odd = 0; cfg_flat = 0; cfg_lanes = 3'b110;
    send_frame(1, "R8 eight ch B on all");
    drain();
    cfg_b_all = 0;
    send_frame(1, "R8 eight ch B on first");
    drain();
    cfg_b_all = 1; cfg_lanes = 3'b001;
    send_frame(0, "R1 three ch rounded");
    drain();

    // R8 wrap of the 192-frame index
    cfg_layout = 0;
    send_frame(1, "R8 wrap start");
    for (int i = 0; i < 192; i++) send_frame(0, "R8 wrap");
    drain();

    // R12 hold under back-pressure
    p_ready = 0;
    send_frame(0, "R12 held packet");
    tick(1);
    held = p_header;
    tick(3);
    chk(p_valid == 1, "R12 stays valid", 256'(p_valid), 1);
    chk(p_header == held, "R12 stable header", 256'(p_header), 256'(held));
    chk(s_ready == 0, "R12 s_ready low while full", 256'(s_ready), 0);
    p_ready = 1;
    drain();

    // R4 silent fill, with a frame arriving inside the window
    cfg_layout = 1; cfg_lanes = 3'b010;
    fill_hdr = {4'b0000, 4'b0011, 3'b000, 1'b1, 4'b0011, 8'h02};
    fill_body = x_body('0, 4);
    fill_seen = 0; fill_ok = 1;
    src_avail = 0;
    tick(12);
    send_frame(0, "R4 frame during underrun");
    tick(12);
    src_avail = 1;
    drain(); tick(4);
    fill_ok = 0;
    chk(fill_seen > 1, "R4 silent packets seen", 256'(fill_seen), 2);

    // R5 null fill
    cfg_silent = 0;
    fill_hdr = '0; fill_body = '0;
    fill_seen = 0; fill_ok = 1;
    src_avail = 0;
    tick(15);
    src_avail = 1;
    tick(4);
    fill_ok = 0;
    chk(fill_seen > 1, "R5 null packets seen", 256'(fill_seen), 2);

    // R11 unsupported format
    cfg_format = 2'b01; src_avail = 0;
    tick(10);
    chk(s_ready == 0, "R11 no accept", 256'(s_ready), 0);
    chk(p_valid == 0, "R11 no packet", 256'(p_valid), 0);
    cfg_format = 2'b00; src_avail = 1;
    tick(2);

    // R10 disable runs to end of active frame
    cfg_enable = 0;
    tick(3);
    chk(s_ready == 1, "R10 still running", 256'(s_ready), 1);
    send_frame(0, "R10 frame after disable");
    drain();
    active_end = 1; tick(1); active_end = 0;
    chk(s_ready == 0, "R10 stopped", 256'(s_ready), 0);
    src_avail = 0;
    tick(10);
    chk(p_valid == 0, "R10 no fill after stop", 256'(p_valid), 0);
    src_avail = 1;
    cfg_enable = 1;
    tick(4);
    chk(s_ready == 0, "R9 re-enable waits", 256'(s_ready), 0);

    done = 1;
    summary();
  end
endmodule